// File: doc/BRIEF.md
# Link statistics counter

Each port of a serial link controller gets one statistics unit with a single wide counter. Software selects what the counter measures. Three measurements take time: received data volume, transmitted data volume, and the number of clock cycles the link spends in a chosen low-power training state. The fourth choice counts one error or non-error event on one chosen lane. Only one measurement runs at a time. Data volume is counted per handshake beat, and each beat stands for 16 bytes.

The controller drives the monitoring inputs. The receive and transmit paths are valid/ready streams, and the unit taps them. A beat counts only in a cycle where both valid and ready are high. The unit drives no ready signal, so it never applies back-pressure. A stalled beat (valid high, ready low) counts nothing, and the stream's own rules decide when a beat completes.

Software uses a small register port. A write to the control register sets the enable bit, the measurement mode, the state selection, the event selection and the lane selection. The same write can clear the counter and clear the wrap flag. Software reads the count as two halves. A read of the low half takes a snapshot of the high half, so the two halves match. The counter raises no interrupt. When it wraps, it sets a sticky flag that software reads and clears.

Top module: `link_stat_counter`

## Requirements
- R1: After reset, the counter is zero and the wrap flag is clear. Enable is off, the mode is 0 and every selection field is 0, so reads of the control register (address 0), the low half (address 1) and the high half (address 2) all return 0.
- R2: In mode 0 the counter adds one for each cycle with `rx_valid && rx_ready`. In mode 1 it adds one for each cycle with `tx_valid && tx_ready`. Each count stands for 16 bytes. A cycle with valid high and ready low adds nothing.
- R3: In mode 2 the counter adds one for each clock cycle in which `link_state` equals the state field, control bits [11:8].
- R4: In mode 3 the counter adds one for each cycle in which the bit of `lane_evt` at index lane*NUM_EVT+event is high. The lane comes from control bits [27:24] and the event from bits [19:16]. Pulses on other lanes or other events add nothing.
- R5: In mode 3, an event code of NUM_EVT or more, or a lane number of NUM_LANES or more, counts nothing.
- R6: While enable (control bit 0) is low, the counter holds its value.
- R7: A control write made while enable is high leaves mode (bits [5:4]) and the state, event and lane fields unchanged, but its enable, clear and wrap-clear bits still take effect. Once enable is low, a write takes the new fields, and counting uses them after the next enable.
- R8: A control write with bit 1 set makes the counter zero at the next clock edge. The clear wins over an increment in the same cycle.
- R9: An increment from all-ones wraps the counter silently to zero and sets the sticky wrap flag (control read bit 3). A control write with bit 2 set clears the flag, except when a wrap happens in that same cycle, in which case the flag stays set.
- R10: A read of address 1 returns the low HALF_W bits and captures the upper bits. A later read of address 2 returns the captured bits, not the live ones.
- R11: `reg_rdata` changes only on the clock edge that samples `reg_rd`, and it holds between reads. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address (0 control, 1 low half, 2 high half) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| rx_valid | input | 1 | Receive stream valid (tapped) |
| rx_ready | input | 1 | Receive stream ready (tapped) |
| tx_valid | input | 1 | Transmit stream valid (tapped) |
| tx_ready | input | 1 | Transmit stream ready (tapped) |
| link_state | input | 4 | Current link-training state code |
| lane_evt | input | NUM_LANES*NUM_EVT | One-cycle event pulses, NUM_EVT bits per lane |

## Verification
The bench builds the block with a 12-bit counter split at 8 bits, 4 lanes and 6 event types. The narrow counter lets a run of a few thousand cycles reach the all-ones wrap and the sticky flag. The 8-bit split means the high half changes between two reads, so the bench can show that the high-half snapshot is coherent. With 6 event types and 4 lanes, a 4-bit event code or lane number can point past the last event or lane, so codes with no meaning are exercised too.

// File: rtl/link_stat_pkg.sv
package link_stat_pkg;
  typedef enum logic [1:0] {
    MODE_RX  = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RES = 2'd2,
    MODE_EVT = 2'd3
  } mon_mode_e;

  localparam int SEL_W = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  localparam int B_EN    = 0;
  localparam int B_CLR   = 1;
  localparam int B_WCLR  = 2;
  localparam int B_WRAP  = 3;
  localparam int B_MODE  = 4;
  localparam int B_STATE = 8;
  localparam int B_EVT   = 16;
  localparam int B_LANE  = 24;
endpackage

// File: rtl/lsc_cfg_regs.sv
module lsc_cfg_regs
  import link_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [31:0]      wdata,
  input  logic             wrap_set,
  output logic             en,
  output logic             clr,
  output mon_mode_e        mode,
  output logic [SEL_W-1:0] st_sel,
  output logic [SEL_W-1:0] evt_sel,
  output logic [SEL_W-1:0] lane_sel,
  output logic             wrap_flag
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:28], wdata[23:20], wdata[15:12], wdata[7:6], wdata[3]};

  assign clr = wr_ctrl & wdata[B_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      mode      <= MODE_RX;
      st_sel    <= '0;
      evt_sel   <= '0;
      lane_sel  <= '0;
      wrap_flag <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en <= wdata[B_EN];
        if (!en) begin
          mode     <= mon_mode_e'(wdata[B_MODE +: 2]);
          st_sel   <= wdata[B_STATE +: SEL_W];
          evt_sel  <= wdata[B_EVT +: SEL_W];
          lane_sel <= wdata[B_LANE +: SEL_W];
        end
      end
      if (wrap_set)
        wrap_flag <= 1'b1;
      else if (wr_ctrl && wdata[B_WCLR])
        wrap_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lsc_inc_sel.sv
module lsc_inc_sel
  import link_stat_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int NUM_EVT   = 6,
  localparam int EVT_BUS_W = NUM_LANES * NUM_EVT
) (
  input  logic                 en,
  input  mon_mode_e            mode,
  input  logic [SEL_W-1:0]     st_sel,
  input  logic [SEL_W-1:0]     evt_sel,
  input  logic [SEL_W-1:0]     lane_sel,
  input  logic                 rx_valid,
  input  logic                 rx_ready,
  input  logic                 tx_valid,
  input  logic                 tx_ready,
  input  logic [SEL_W-1:0]     link_state,
  input  logic [EVT_BUS_W-1:0] lane_evt,
  output logic                 inc
);
  logic [EVT_BUS_W-1:0] hit_vec;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      assign hit_vec[l*NUM_EVT + e] = lane_evt[l*NUM_EVT + e]
                                      && (lane_sel == SEL_W'(l))
                                      && (evt_sel == SEL_W'(e));
    end
  end

  logic evt_hit;
  assign evt_hit = |hit_vec;

  always_comb begin
    inc = 1'b0;
    if (en) begin
      unique case (mode)
        MODE_RX:  inc = rx_valid & rx_ready;
        MODE_TX:  inc = tx_valid & tx_ready;
        MODE_RES: inc = (link_state == st_sel);
        MODE_EVT: inc = evt_hit;
        default:  inc = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsc_counter.sv
module lsc_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_set
);
  assign wrap_set = inc & ~clr & (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/link_stat_counter.sv
module link_stat_counter
  import link_stat_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int NUM_EVT   = 6,
  parameter int CNT_W     = 64,
  parameter int HALF_W    = 32,
  localparam int EVT_BUS_W = NUM_LANES * NUM_EVT,
  localparam int HI_W      = CNT_W - HALF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 rx_valid,
  input  logic                 rx_ready,
  input  logic                 tx_valid,
  input  logic                 tx_ready,
  input  logic [3:0]           link_state,
  input  logic [EVT_BUS_W-1:0] lane_evt
);
  logic             en_q, clr, inc, wrap_set, wrap_q;
  mon_mode_e        mode_q;
  logic [SEL_W-1:0] st_q, evt_q, lane_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  hi_snap_q;
  logic             wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

  lsc_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wdata     (reg_wdata),
    .wrap_set  (wrap_set),
    .en        (en_q),
    .clr       (clr),
    .mode      (mode_q),
    .st_sel    (st_q),
    .evt_sel   (evt_q),
    .lane_sel  (lane_q),
    .wrap_flag (wrap_q)
  );

  lsc_inc_sel #(.NUM_LANES(NUM_LANES), .NUM_EVT(NUM_EVT)) u_sel (
    .en         (en_q),
    .mode       (mode_q),
    .st_sel     (st_q),
    .evt_sel    (evt_q),
    .lane_sel   (lane_q),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .link_state (link_state),
    .lane_evt   (lane_evt),
    .inc        (inc)
  );

  lsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .inc      (inc),
    .cnt      (cnt_q),
    .wrap_set (wrap_set)
  );

  logic [31:0] ctrl_img;
  always_comb begin
    ctrl_img = '0;
    ctrl_img[B_EN]             = en_q;
    ctrl_img[B_WRAP]           = wrap_q;
    ctrl_img[B_MODE +: 2]      = mode_q;
    ctrl_img[B_STATE +: SEL_W] = st_q;
    ctrl_img[B_EVT +: SEL_W]   = evt_q;
    ctrl_img[B_LANE +: SEL_W]  = lane_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_snap_q <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_CTRL: reg_rdata <= ctrl_img;
        ADDR_LO: begin
          reg_rdata <= 32'(cnt_q[HALF_W-1:0]);
          hi_snap_q <= cnt_q[CNT_W-1:HALF_W];
        end
        ADDR_HI:   reg_rdata <= 32'(hi_snap_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int CNT_W  = 64,
  parameter int HALF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             en_q,
  input logic             wrap_q,
  input logic [1:0]       mode_q,
  input logic [3:0]       st_q,
  input logic [3:0]       evt_q,
  input logic [3:0]       lane_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-HALF_W-1:0] hi_snap_q
);
  logic wr_c;
  assign wr_c = reg_wr && (reg_addr == 2'd0);

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && reg_wdata[1]) |=> (cnt_q == '0));

  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !(wr_c && reg_wdata[1])) |=> $stable(cnt_q));

  a_r7_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && wr_c) |=> ($stable(mode_q) && $stable(st_q) && $stable(evt_q) && $stable(lane_q)));

  a_r9_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_c && reg_wdata[1]) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  a_r9_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_q && !(wr_c && reg_wdata[2])) |=> wrap_q);

  a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1) |=> (hi_snap_q == $past(cnt_q[CNT_W-1:HALF_W])));
endmodule

bind link_stat_counter lsc_checker #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .en_q      (en_q),
  .wrap_q    (wrap_q),
  .mode_q    (mode_q),
  .st_q      (st_q),
  .evt_q     (evt_q),
  .lane_q    (lane_q),
  .cnt_q     (cnt_q),
  .hi_snap_q (hi_snap_q)
);

// File: tb/test_link_stat_counter.sv
module test_link_stat_counter;
  localparam int NL = 4;
  localparam int NE = 6;
  localparam int CW = 12;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic rx_valid = 1'b0, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready = 1'b0;
  logic [3:0] link_state = '0;
  logic [NL*NE-1:0] lane_evt = '0;

  always #4 clk = ~clk;

  link_stat_counter #(.NUM_LANES(NL), .NUM_EVT(NE), .CNT_W(CW), .HALF_W(HW)) i_link_stat_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .link_state(link_state), .lane_evt(lane_evt)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [CW-1:0] m_cnt;
  logic [CW-HW-1:0] m_snap;
  logic m_en, m_wrap;
  int m_mode, m_st, m_evt, m_lane;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_snap = '0; m_en = 0; m_wrap = 0;
      m_mode = 0; m_st = 0; m_evt = 0; m_lane = 0; m_rd = '0;
    end else begin
      bit incr;
      bit clr_now;
      if (reg_rd) begin
        case (reg_addr)
          2'd0: begin
            m_rd = '0; m_rd[0] = m_en; m_rd[3] = m_wrap;
            m_rd[5:4] = 2'(m_mode); m_rd[11:8] = 4'(m_st);
            m_rd[19:16] = 4'(m_evt); m_rd[27:24] = 4'(m_lane);
          end
          2'd1: begin m_rd = 32'(m_cnt % (1 << HW)); m_snap = (CW-HW)'(m_cnt / (1 << HW)); end
          2'd2: m_rd = 32'(m_snap);
          default: m_rd = '0;
        endcase
      end
      incr = 0;
      if (m_en) begin
        case (m_mode)
          0: incr = rx_valid && rx_ready;
          1: incr = tx_valid && tx_ready;
          2: incr = (int'(link_state) == m_st);
          default: incr = (m_lane < NL && m_evt < NE) ? lane_evt[m_lane*NE + m_evt] : 1'b0;
        endcase
      end
      clr_now = reg_wr && reg_addr == 2'd0 && reg_wdata[1];
      if (reg_wr && reg_addr == 2'd0 && reg_wdata[2]) m_wrap = 0;
      if (clr_now) m_cnt = '0;
      else if (incr) begin
        if (m_cnt == {CW{1'b1}}) m_wrap = 1;
        m_cnt = m_cnt + 1'b1;
      end
      if (reg_wr && reg_addr == 2'd0) begin
        if (!m_en) begin
          m_mode = int'(reg_wdata[5:4]); m_st = int'(reg_wdata[11:8]);
          m_evt = int'(reg_wdata[19:16]); m_lane = int'(reg_wdata[27:24]);
        end
        m_en = reg_wdata[0];
      end
    end
  end

  // compare read port against model on every clock (R11 covers hold between reads)
  always @(negedge clk) if (rst_n) check({cur_req, "/R11"}, reg_rdata, m_rd);

  // traffic generator
  bit traffic = 0;
  bit pin_state = 0;
  logic [3:0] pinned = '0;
  always @(negedge clk) begin
    if (traffic) begin
      rx_valid <= 1'($urandom); rx_ready <= 1'($urandom);
      tx_valid <= 1'($urandom); tx_ready <= 1'($urandom);
      link_state <= pin_state ? pinned : 4'($urandom % 8);
      for (int i = 0; i < NL*NE; i++) lane_evt[i] <= ($urandom % 4) == 0;
    end else begin
      rx_valid <= 0; rx_ready <= 0; tx_valid <= 0; tx_ready <= 0; lane_evt <= '0;
      link_state <= pin_state ? pinned : 4'hf;
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 2'd0; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input bit en, input int mode, input int st, input int ev, input int ln);
    logic [31:0] c = '0;
    c[0] = en; c[5:4] = 2'(mode); c[11:8] = 4'(st); c[19:16] = 4'(ev); c[27:24] = 4'(ln);
    return c;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    rd(2'd0, v); check("R1", v, 32'h0);
    rd(2'd1, v); check("R1", v, 32'h0);
    rd(2'd2, v); check("R1", v, 32'h0);
    // R2 receive and transmit throughput
    cur_req = "R2";
    wr(ctl(1, 0, 0, 0, 0) | 32'h2); traffic = 1; repeat (150) @(negedge clk);
    traffic = 0; wr(ctl(0, 0, 0, 0, 0)); rd(2'd1, v); rd(2'd2, v);
    wr(ctl(1, 1, 0, 0, 0) | 32'h2); traffic = 1; repeat (150) @(negedge clk);
    traffic = 0; wr(ctl(0, 1, 0, 0, 0)); rd(2'd1, v); rd(2'd2, v);
    // R3 state residency
    cur_req = "R3";
    wr(ctl(1, 2, 5, 0, 0) | 32'h2); traffic = 1; repeat (120) @(negedge clk);
    traffic = 0; wr(ctl(0, 2, 5, 0, 0)); rd(2'd1, v);
    // R4 selected lane event
    cur_req = "R4";
    wr(ctl(1, 3, 0, 3, 2) | 32'h2); traffic = 1; repeat (120) @(negedge clk);
    traffic = 0; wr(ctl(0, 3, 0, 3, 2)); rd(2'd1, v);
    // R5 undefined lane / event code
    cur_req = "R5";
    wr(ctl(1, 3, 0, 1, 7) | 32'h2); traffic = 1; repeat (80) @(negedge clk);
    traffic = 0; wr(ctl(0, 3, 0, 1, 7)); rd(2'd1, v); check("R5", v, 32'h0);
    wr(ctl(1, 3, 0, 9, 1)); traffic = 1; repeat (80) @(negedge clk);
    traffic = 0; wr(ctl(0, 3, 0, 9, 1)); rd(2'd1, v); check("R5", v, 32'h0);
    // R6 disabled holds
    cur_req = "R6";
    wr(ctl(1, 2, 5, 0, 0) | 32'h2); traffic = 1; repeat (60) @(negedge clk);
    wr(ctl(0, 2, 5, 0, 0)); rd(2'd1, v);
    repeat (60) @(negedge clk); rd(2'd1, v2); check("R6", v2, v); traffic = 0;
    // R7 selection locked while enabled
    cur_req = "R7";
    wr(ctl(1, 0, 0, 0, 0) | 32'h2);
    wr(ctl(1, 3, 4, 2, 1));
    rd(2'd0, v); check("R7", v, ctl(1, 0, 0, 0, 0));
    traffic = 1; repeat (60) @(negedge clk); traffic = 0;
    wr(ctl(0, 3, 4, 2, 1)); rd(2'd0, v); check("R7", v, ctl(0, 0, 0, 0, 0));
    wr(ctl(0, 3, 4, 2, 1)); rd(2'd0, v); check("R7", v, ctl(0, 3, 4, 2, 1));
    wr(ctl(1, 3, 4, 2, 1)); traffic = 1; repeat (60) @(negedge clk); traffic = 0;
    wr(ctl(0, 3, 4, 2, 1));
    // R8 clear beats increment
    cur_req = "R8";
    pinned = 4'd6; pin_state = 1;
    wr(ctl(1, 2, 6, 0, 0)); repeat (20) @(negedge clk);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = ctl(1, 2, 6, 0, 0) | 32'h2;
    @(negedge clk); reg_wdata = ctl(0, 2, 6, 0, 0);
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
    rd(2'd1, v); check("R8", v, 32'h1);
    // R9 wrap and sticky flag
    cur_req = "R9";
    wr(ctl(1, 2, 6, 0, 0) | 32'h2); repeat (4100) @(negedge clk);
    rd(2'd0, v); check("R9", {31'h0, v[3]}, 32'h1);
    rd(2'd2, v); rd(2'd1, v);
    wr(ctl(1, 2, 6, 0, 0) | 32'h4);
    rd(2'd0, v); check("R9", {31'h0, v[3]}, 32'h0);
    // R10 coherent halves
    cur_req = "R10";
    wr(ctl(1, 2, 6, 0, 0) | 32'h2); repeat (250) @(negedge clk);
    rd(2'd1, v); repeat (40) @(negedge clk);
    rd(2'd2, v2); check("R10", v2, 32'h0);
    rd(2'd1, v); rd(2'd2, v2); check("R10", v2, 32'h1);
    // R11 spare address
    cur_req = "R11";
    rd(2'd3, v); check("R11", v, 32'h0);
    pin_state = 0; wr(ctl(0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    summary();
  end
endmodule